// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial-flash command at a time for a single flash device on an SPI mode 3 bus. Software fills an address register and a data register as needed, then writes one command word. The command word gives the opcode, how many address bytes, dummy bytes and data bytes to move, the data direction, and whether chip select stays asserted once the command ends. The engine then sends the opcode, the low address bytes with the most significant first, zero dummy bytes, and up to four data bytes. Data goes out from the data register, or comes in and is stored there.

Chip select can stay asserted from one command to the next. A long flash transaction, such as a page program or a bulk read, is therefore built from a chain of short commands of at most four data bytes. A command issued while chip select is still held skips the opcode phase and carries on the same bus transaction. A status register shows whether a command is still running. It also has a sticky error flag for rejected command writes. The serial clock runs at a programmable fraction of the block clock.

Top module: `sfc_sequencer`

## Requirements
- R1: The command word at register offset 0 has these fields: bits 7:0 opcode, 9:8 address bytes (0 to 3), 13:10 dummy bytes (0 to 15), 16:14 data bytes (0 to 4), bit 17 direction (1 = write to flash), bit 18 keep-select, bits 20:19 device select. A command that starts with chip select released sends the opcode first. Every byte on the bus goes out most significant bit first.
- R2: After the opcode, the address phase sends the low N bytes of the 24-bit address register (offset 1), most significant of those first. N is the address-byte count.
- R3: After the address, the dummy phase drives zero on the data-out line for the programmed number of bytes.
- R4: In a write command, the data phase sends bytes from the data register (offset 2) in little-endian order: bits 7:0 go first.
- R5: In a read command, the received bytes are stored little-endian in the data register, with the first byte in bits 7:0. Data register bytes at or above the data-byte count read back as zero.
- R6: When keep-select is set, chip select stays low after the command ends. The next command sends no opcode and starts with its address, dummy or data phase.
- R7: A command that moves no bits while chip select is held releases chip select at once if keep-select is clear, and produces no serial clock pulses.
- R8: Status bit 0 (pending, offset 3) is set from the cycle after a command is accepted until the command ends. For a read, the data register already holds the received data when pending clears. Chip select is low while a command is pending.
- R9: A command write while a command is pending is ignored and sets status bit 1 (error). The error bit stays set until software writes 1 to status bit 1.
- R10: A command with a data-byte count above 4, or a nonzero device select, is ignored and sets the error bit. It causes no bus activity.
- R11: The serial clock idles high and is always high while chip select is high. Data-out changes only while the clock is low or between commands, and data-in is sampled at the rising edge.
- R12: The divider register (offset 4) sets each clock half-period to 1 to 6 block cycles. Writes of values outside 1 to 6 are ignored.
- R13: After reset, status reads 0, the divider reads 1, chip select is high, the serial clock is high and data-out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset: 0 command, 1 address, 2 data, 3 status, 4 divider |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at reg_addr |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions check on every cycle the properties that need no knowledge of the command contents. The clock is high whenever chip select is released. Chip select is low while a command is pending. Data-out holds steady through each high clock phase. The error bit is set by a command write during a pending command, holds until it is cleared by writing 1 to status bit 1, and drops when cleared. The bench's scenarios are needed for the rest: the byte order of the opcode, address, dummy and data phases, the skipped opcode on a held chip select, the read-data packing with zeroed upper bytes, and the divider's half-period length. For these the bench records every bit on the bus and compares the stream with byte lists it builds from the command words.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int ADDR_W = 24;
    localparam int WORD_W = 32;
    localparam int REG_SEL_W = 3;

    localparam logic [REG_SEL_W-1:0] OFS_CMD = 3'd0;
    localparam logic [REG_SEL_W-1:0] OFS_ADR = 3'd1;
    localparam logic [REG_SEL_W-1:0] OFS_DAT = 3'd2;
    localparam logic [REG_SEL_W-1:0] OFS_STA = 3'd3;
    localparam logic [REG_SEL_W-1:0] OFS_DIV = 3'd4;

    localparam logic [2:0] MAX_DATA_BYTES = 3'd4;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADR,
        PH_DUM,
        PH_DAT,
        PH_END
    } phase_e;

    // Field order here matches the command word, most significant first.
    typedef struct packed {
        logic [1:0] sel;
        logic       keep;
        logic       wr;
        logic [2:0] dlen;
        logic [3:0] dum;
        logic [1:0] alen;
        logic [7:0] opc;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    function automatic cmd_t unpack_cmd(input logic [WORD_W-1:0] w);
        return cmd_t'(w[CMD_W-1:0]);
    endfunction

    // Phase that follows p; a phase with zero bytes is skipped.
    function automatic phase_e phase_after(input phase_e p, input cmd_t c);
        phase_e r;
        r = PH_END;
        if (p == PH_OPC) begin
            if (c.alen != 2'd0)      r = PH_ADR;
            else if (c.dum != 4'd0)  r = PH_DUM;
            else if (c.dlen != 3'd0) r = PH_DAT;
        end else if (p == PH_ADR) begin
            if (c.dum != 4'd0)       r = PH_DUM;
            else if (c.dlen != 3'd0) r = PH_DAT;
        end else if (p == PH_DUM) begin
            if (c.dlen != 3'd0)      r = PH_DAT;
        end
        return r;
    endfunction

    function automatic logic [3:0] phase_len(input phase_e p, input cmd_t c);
        case (p)
            PH_OPC:  return 4'd1;
            PH_ADR:  return {2'b00, c.alen};
            PH_DUM:  return c.dum;
            PH_DAT:  return {1'b0, c.dlen};
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/sfc_sck_timer.sv
// Serial clock generator: each half-period lasts div block cycles.
module sfc_sck_timer #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [DIV_W-1:0] div,
    input  logic             hold_high,
    output logic             sck,
    output logic             lo_done,
    output logic             hi_done
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic             lvl;
        logic [DIV_W-1:0] cnt;
    } tim_t;

    tim_t s_q, s_d;
    logic wrap;

    always_comb begin
        wrap    = (s_q.cnt == (div - ONE));
        lo_done = active && !s_q.lvl && wrap;
        hi_done = active && s_q.lvl && wrap;
        s_d     = s_q;
        if (!active) begin
            s_d.lvl = 1'b1;
            s_d.cnt = '0;
        end else if (wrap) begin
            s_d.cnt = '0;
            // After the final bit the clock stays at its idle level.
            s_d.lvl = (hi_done && hold_high) ? 1'b1 : !s_q.lvl;
        end else begin
            s_d.cnt = s_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.lvl <= 1'b1;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sck = s_q.lvl;

endmodule

// File: rtl/sfc_shift_ctrl.sv
// Phase sequencer and shifter for one command.
module sfc_shift_ctrl
    import sfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] txdata,
    input  logic              lo_done,
    input  logic              hi_done,
    input  logic              miso,
    output logic              busy,
    output logic              cs_n,
    output logic              mosi,
    output logic              last_bit,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_word
);
    typedef struct packed {
        logic              busy;
        logic              held;
        phase_e            ph;
        logic [3:0]        byte_idx;
        logic [2:0]        bit_idx;
        logic              sampled;
        logic [7:0]        rxsh;
        logic [WORD_W-1:0] rxw;
        cmd_t              c;
        logic [ADDR_W-1:0] adr;
        logic [WORD_W-1:0] tx;
    } sh_t;

    sh_t s_q, s_d;

    logic [3:0] cur_len;
    logic       byte_last;
    phase_e     nxt;
    phase_e     first;
    logic [1:0] asel;
    logic [7:0] cur_byte;

    always_comb begin
        cur_len   = phase_len(s_q.ph, s_q.c);
        byte_last = (s_q.byte_idx == (cur_len - 4'd1));
        nxt       = phase_after(s_q.ph, s_q.c);
        last_bit  = s_q.busy && (s_q.bit_idx == 3'd7) && byte_last && (nxt == PH_END);

        // Address bytes: most significant of the selected ones first.
        asel = s_q.c.alen - 2'd1 - s_q.byte_idx[1:0];
        case (s_q.ph)
            PH_OPC:  cur_byte = s_q.c.opc;
            PH_ADR:  cur_byte = 8'(s_q.adr >> {asel, 3'b000});
            PH_DAT:  cur_byte = s_q.c.wr ? 8'(s_q.tx >> {s_q.byte_idx[1:0], 3'b000}) : 8'h00;
            default: cur_byte = 8'h00;
        endcase
        mosi = s_q.busy ? cur_byte[3'd7 - s_q.bit_idx] : 1'b0;

        first    = s_q.held ? phase_after(PH_OPC, cmd) : PH_OPC;
        s_d      = s_q;
        rx_valid = 1'b0;

        if (launch) begin
            s_d.c        = cmd;
            s_d.adr      = addr;
            s_d.tx       = txdata;
            s_d.rxw      = '0;
            s_d.byte_idx = '0;
            s_d.bit_idx  = '0;
            s_d.sampled  = 1'b0;
            s_d.ph       = first;
            if (first == PH_END) begin
                s_d.held = cmd.keep;
            end else begin
                s_d.busy = 1'b1;
            end
        end else if (s_q.busy) begin
            if (lo_done) begin
                s_d.rxsh    = {s_q.rxsh[6:0], miso};
                s_d.sampled = 1'b1;
            end
            if (hi_done && s_q.sampled) begin
                s_d.sampled = 1'b0;
                s_d.bit_idx = s_q.bit_idx + 3'd1;
                if (s_q.bit_idx == 3'd7) begin
                    if (s_q.ph == PH_DAT && !s_q.c.wr) begin
                        s_d.rxw[{s_q.byte_idx[1:0], 3'b000} +: 8] = s_q.rxsh;
                    end
                    if (byte_last) begin
                        s_d.byte_idx = '0;
                        s_d.ph       = nxt;
                        if (nxt == PH_END) begin
                            s_d.busy = 1'b0;
                            s_d.held = s_q.c.keep;
                            rx_valid = !s_q.c.wr;
                        end
                    end else begin
                        s_d.byte_idx = s_q.byte_idx + 4'd1;
                    end
                end
            end
        end
        rx_word = s_d.rxw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.busy     <= 1'b0;
            s_q.held     <= 1'b0;
            s_q.ph       <= PH_END;
            s_q.byte_idx <= '0;
            s_q.bit_idx  <= '0;
            s_q.sampled  <= 1'b0;
            s_q.rxsh     <= '0;
            s_q.rxw      <= '0;
            s_q.c        <= '0;
            s_q.adr      <= '0;
            s_q.tx       <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = s_q.busy;
    assign cs_n = !(s_q.busy || s_q.held);

endmodule

// File: rtl/sfc_regs.sv
// Register file, command acceptance and error flag.
module sfc_regs
    import sfc_pkg::*;
#(
    parameter int DIV_MAX = 6,
    parameter int NUM_DEV = 1,
    parameter int DIV_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_SEL_W-1:0] reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic                 busy,
    input  logic                 rx_valid,
    input  logic [WORD_W-1:0]    rx_word,
    output logic                 launch,
    output cmd_t                 cmd,
    output logic [ADDR_W-1:0]    addr,
    output logic [WORD_W-1:0]    txdata,
    output logic [DIV_W-1:0]     div,
    output logic                 err
);
    typedef struct packed {
        logic [WORD_W-1:0] cmd_word;
        logic [ADDR_W-1:0] adr;
        logic [WORD_W-1:0] dat;
        logic [DIV_W-1:0]  div;
        logic              err;
    } rf_t;

    rf_t  r_q, r_d;
    cmd_t cmd_in;
    logic cmd_hit;
    logic legal;

    always_comb begin
        cmd_in  = unpack_cmd(reg_wdata);
        cmd_hit = reg_wr && (reg_addr == OFS_CMD);
        legal   = (cmd_in.dlen <= MAX_DATA_BYTES) && (int'(cmd_in.sel) < NUM_DEV);
        launch  = cmd_hit && !busy && legal;

        r_d = r_q;
        if (cmd_hit && !launch) r_d.err = 1'b1;
        if (launch) r_d.cmd_word = reg_wdata;
        if (reg_wr && reg_addr == OFS_ADR) r_d.adr = reg_wdata[ADDR_W-1:0];
        if (reg_wr && reg_addr == OFS_DAT) r_d.dat = reg_wdata;
        if (rx_valid) r_d.dat = rx_word;
        if (reg_wr && reg_addr == OFS_STA && reg_wdata[1]) r_d.err = 1'b0;
        if (reg_wr && reg_addr == OFS_DIV && reg_wdata != '0 && reg_wdata <= WORD_W'(DIV_MAX)) begin
            r_d.div = reg_wdata[DIV_W-1:0];
        end

        case (reg_addr)
            OFS_CMD: reg_rdata = r_q.cmd_word;
            OFS_ADR: reg_rdata = WORD_W'(r_q.adr);
            OFS_DAT: reg_rdata = r_q.dat;
            OFS_STA: reg_rdata = {{(WORD_W-2){1'b0}}, r_q.err, busy};
            OFS_DIV: reg_rdata = WORD_W'(r_q.div);
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cmd_word <= '0;
            r_q.adr      <= '0;
            r_q.dat      <= '0;
            r_q.div      <= DIV_W'(1);
            r_q.err      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd    = cmd_in;
    assign addr   = r_q.adr;
    assign txdata = r_q.dat;
    assign div    = r_q.div;
    assign err    = r_q.err;

endmodule

// File: rtl/sfc_sequencer.sv
module sfc_sequencer
    import sfc_pkg::*;
#(
    parameter int DIV_MAX = 6,
    parameter int NUM_DEV = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int DIV_W = $clog2(DIV_MAX + 1);

    logic              launch;
    cmd_t              cmd;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] txdata;
    logic [DIV_W-1:0]  div;
    logic              pending;
    logic              cmd_error;
    logic              rx_valid;
    logic [WORD_W-1:0] rx_word;
    logic              lo_done;
    logic              hi_done;
    logic              last_bit;

    sfc_regs #(
        .DIV_MAX (DIV_MAX),
        .NUM_DEV (NUM_DEV),
        .DIV_W   (DIV_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (pending),
        .rx_valid  (rx_valid),
        .rx_word   (rx_word),
        .launch    (launch),
        .cmd       (cmd),
        .addr      (addr),
        .txdata    (txdata),
        .div       (div),
        .err       (cmd_error)
    );

    sfc_shift_ctrl u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .cmd      (cmd),
        .addr     (addr),
        .txdata   (txdata),
        .lo_done  (lo_done),
        .hi_done  (hi_done),
        .miso     (spi_miso),
        .busy     (pending),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .last_bit (last_bit),
        .rx_valid (rx_valid),
        .rx_word  (rx_word)
    );

    sfc_sck_timer #(
        .DIV_W (DIV_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (pending),
        .div       (div),
        .hold_high (last_bit),
        .sck       (spi_sck),
        .lo_done   (lo_done),
        .hi_done   (hi_done)
    );

endmodule

// File: rtl/sfc_sequencer_chk.sv
module sfc_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       clr_bit,
    input logic       spi_sck,
    input logic       spi_cs_n,
    input logic       spi_mosi,
    input logic       pending,
    input logic       cmd_error
);
    assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_sck);

    assert_pending_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !spi_cs_n);

    assert_mosi_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && $past(pending) && spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    assert_busy_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && pending) |=> cmd_error);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_error && !(reg_wr && reg_addr == 3'd3 && clr_bit)) |=> cmd_error);

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd3 && clr_bit) |=> !cmd_error);

endmodule

bind sfc_sequencer sfc_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .clr_bit   (reg_wdata[1]),
    .spi_sck   (spi_sck),
    .spi_cs_n  (spi_cs_n),
    .spi_mosi  (spi_mosi),
    .pending   (pending),
    .cmd_error (cmd_error)
);

// File: tb/sim_sfc_sequencer.sv
`timescale 1ns/100ps
module sim_sfc_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;
    int exp_div = 1;
    int lo_len = 0;
    logic prev_sck = 1'b1;

    bit         bitq[$];
    bit         misoq[$];
    logic [7:0] expq[$];

    sfc_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Behavioural flash side: records data-out at each rising clock edge,
    // presents the next data-in bit after each falling edge, and tracks
    // the low half-period length and idle level every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!spi_cs_n && !prev_sck && spi_sck) begin
                bitq.push_back(spi_mosi);
                chk(lo_len == exp_div, "R12", "low half-period", lo_len, exp_div);
            end
            if (!spi_cs_n && prev_sck && !spi_sck) begin
                spi_miso = (misoq.size() != 0) ? misoq.pop_front() : 1'b0;
            end
            if (spi_cs_n && !spi_sck) chk(0, "R11", "clock low while deselected", 0, 1);
            lo_len = spi_sck ? 0 : lo_len + 1;
            prev_sck = spi_sck;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(0, "WDOG", "watchdog expired", cycles, 150000);
            summary();
        end
    end

    function automatic logic [31:0] mk(input logic [7:0] opc, input logic [1:0] alen,
                                       input logic [3:0] dum, input logic [2:0] dlen,
                                       input bit wr, input bit keep, input logic [1:0] sel);
        return {11'b0, sel, keep, wr, dlen, dum, alen, opc};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic push_miso(input logic [7:0] b);
        for (int k = 7; k >= 0; k--) misoq.push_back(b[k]);
    endtask

    // Waits for pending to drop; at that cycle the data register is read.
    task automatic wait_done(output logic [31:0] dat);
        logic [31:0] s;
        int n;
        n = 0;
        s = 32'd1;
        while (s[0] && n < 20000) begin
            @(negedge clk);
            #0.2;
            rd(3'd3, s);
            n++;
        end
        rd(3'd2, dat);
        chk(n < 20000, "R8", "command completes", n, 0);
    endtask

    task automatic check_bus(input string req);
        int nb;
        nb = bitq.size() / 8;
        chk(bitq.size() == 8 * expq.size(), req, "bus bit count", bitq.size(), 8 * expq.size());
        for (int i = 0; i < expq.size() && i < nb; i++) begin
            logic [7:0] b;
            b = 8'h00;
            for (int k = 0; k < 8; k++) b = {b[6:0], bitq[8 * i + k]};
            chk(b == expq[i], req, "bus byte", b, expq[i]);
        end
        bitq.delete();
        expq.delete();
        misoq.delete();
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        rd(3'd3, v); chk(v == 0, "R13", "status after reset", v, 0);
        rd(3'd4, v); chk(v == 1, "R13", "divider after reset", v, 1);
        chk(spi_cs_n == 1 && spi_sck == 1 && spi_mosi == 0, "R13", "bus idle levels",
            {spi_cs_n, spi_sck, spi_mosi}, 3'b110);

        // R1: opcode-only command, released afterwards
        wr(3'd0, mk(8'h06, 0, 0, 0, 1, 0, 0));
        rd(3'd3, v); chk(v[0] == 1, "R8", "pending after accept", v[0], 1);
        wait_done(v);
        expq.push_back(8'h06);
        check_bus("R1");
        chk(spi_cs_n == 1, "R1", "select released", spi_cs_n, 1);

        // R2 R4: three address bytes, four write bytes
        wr(3'd1, 32'h00123456);
        wr(3'd2, 32'hDDCCBBAA);
        wr(3'd0, mk(8'h02, 3, 0, 4, 1, 0, 0));
        wait_done(v);
        foreach (expq[i]) ;
        expq = '{8'h02, 8'h12, 8'h34, 8'h56, 8'hAA, 8'hBB, 8'hCC, 8'hDD};
        check_bus("R4");

        // R3 R5 R6: read with dummy bytes, held select, then a continuation
        wr(3'd1, 32'h00000010);
        for (int i = 0; i < 6; i++) push_miso(8'h00);
        push_miso(8'h5A); push_miso(8'hC3); push_miso(8'h81);
        wr(3'd0, mk(8'h0B, 3, 2, 3, 0, 1, 0));
        wait_done(v);
        chk(v == 32'h0081C35A, "R5", "read data packing", v, 32'h0081C35A);
        expq = '{8'h0B, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        check_bus("R3");
        chk(spi_cs_n == 0, "R6", "select held after keep", spi_cs_n, 0);
        wr(3'd2, 32'hFFFFFFFF);
        push_miso(8'h11); push_miso(8'h22);
        wr(3'd0, mk(8'h0B, 0, 0, 2, 0, 0, 0));
        wait_done(v);
        chk(v == 32'h00002211, "R5", "upper bytes cleared", v, 32'h00002211);
        expq = '{8'h00, 8'h00};
        check_bus("R6");
        chk(spi_cs_n == 1, "R6", "select released at end", spi_cs_n, 1);

        // R2 R7: two address bytes held, then release-only command
        wr(3'd1, 32'h00ABCDEF);
        wr(3'd0, mk(8'h20, 2, 0, 0, 1, 1, 0));
        wait_done(v);
        expq = '{8'h20, 8'hCD, 8'hEF};
        check_bus("R2");
        chk(spi_cs_n == 0, "R7", "select held before release", spi_cs_n, 0);
        wr(3'd0, mk(8'h00, 0, 0, 0, 1, 0, 0));
        chk(spi_cs_n == 1, "R7", "select released by empty command", spi_cs_n, 1);
        rd(3'd3, v); chk(v == 0, "R7", "no pending for empty command", v, 0);
        repeat (10) @(negedge clk);
        check_bus("R7");

        // R9: command during pending is rejected, error sticky, cleared by 1
        wr(3'd1, 32'h00000000);
        for (int i = 0; i < 4; i++) push_miso(8'h00);
        push_miso(8'h10); push_miso(8'h20); push_miso(8'h30); push_miso(8'h40);
        wr(3'd0, mk(8'h03, 3, 0, 4, 0, 0, 0));
        wr(3'd0, mk(8'h99, 0, 0, 0, 1, 0, 0));
        rd(3'd3, v); chk(v == 3, "R9", "error and pending", v, 3);
        wr(3'd3, 32'h1);
        rd(3'd3, v); chk(v[1] == 1, "R9", "error sticky on write of 0", v[1], 1);
        wait_done(v);
        chk(v == 32'h40302010, "R8", "read data present at completion", v, 32'h40302010);
        expq = '{8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        check_bus("R9");
        wr(3'd3, 32'h2);
        rd(3'd3, v); chk(v == 0, "R9", "error cleared", v, 0);

        // R10: illegal data length and device select
        wr(3'd0, mk(8'h02, 0, 0, 5, 1, 0, 0));
        rd(3'd3, v); chk(v == 2, "R10", "error on data length 5", v, 2);
        wr(3'd3, 32'h2);
        wr(3'd0, mk(8'h02, 0, 0, 1, 1, 0, 1));
        rd(3'd3, v); chk(v == 2, "R10", "error on device select 1", v, 2);
        repeat (20) @(negedge clk);
        chk(spi_cs_n == 1, "R10", "no select on rejected command", spi_cs_n, 1);
        check_bus("R10");
        wr(3'd3, 32'h2);

        // R12: divider writes and half-period length
        wr(3'd4, 32'd3);
        rd(3'd4, v); chk(v == 3, "R12", "divider set", v, 3);
        wr(3'd4, 32'd7);
        rd(3'd4, v); chk(v == 3, "R12", "divider 7 ignored", v, 3);
        wr(3'd4, 32'd0);
        rd(3'd4, v); chk(v == 3, "R12", "divider 0 ignored", v, 3);
        exp_div = 3;
        wr(3'd0, mk(8'hAB, 0, 0, 0, 1, 0, 0));
        wait_done(v);
        expq = '{8'hAB};
        check_bus("R12");
        wr(3'd4, 32'd6);
        exp_div = 6;
        wr(3'd2, 32'h000000C5);
        wr(3'd0, mk(8'h5C, 0, 0, 1, 1, 0, 0));
        wait_done(v);
        expq = '{8'h5C, 8'hC5};
        check_bus("R12");

        repeat (5) @(negedge clk);
        summary();
    end
endmodule